// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block collects a set of level-sensitive interrupt lines and presents two request outputs: a normal request and a fast request. It captures every line into a raw level register. Each output has its own enable mask. An output is asserted whenever any captured line that is enabled for it is high. Software reaches the block over a small word-addressed register bus. It reads the raw and masked status and changes the masks through separate set and clear words.

Line 0 is shared with a software trigger. A set word and a clear word can force its raw bit high or low, and the next change on the hardware line 0 takes the raw bit back. Controllers can be chained: the normal-request output of one instance can feed a source line of another instance.

Top module: `lvlint_ctrl`

## Requirements
- R1: After reset the raw level register and both enable masks are zero. Every readable word (0, 1, 2, 4, 8, 9, 10) returns zero, and both outputs are low.
- R2: Raw bits 1 and above take the value of their source line at each clock edge. The raw level reads back at word 1 and also at word 9.
- R3: A write to word 2 ORs the write data into the normal enable mask. Word 2 reads that mask back.
- R4: A write to word 3 clears each normal-mask bit whose write-data bit is 1 and leaves the other mask bits unchanged.
- R5: The fast enable mask is set through word 10 and cleared through word 11. Word 10 reads it back.
- R6: Word 0 reads the raw level AND the normal mask. Word 8 reads the raw level AND the fast mask.
- R7: `irq_o` is high exactly when the raw level AND the normal mask is non-zero, and `fiq_o` is high exactly when the raw level AND the fast mask is non-zero. Both outputs are driven from registered state, so they change at the same edge as the state they depend on.
- R8: A write to word 4 with data bit 0 set forces raw bit 0 to 1. A write to word 5 with data bit 0 set forces raw bit 0 to 0. Writes to these words with data bit 0 clear change nothing. Word 4 reads raw bit 0 in bit 0, and its upper bits read 0.
- R9: Raw bit 0 takes a new value from source line 0 only when that line changes level; while the line holds steady, raw bit 0 keeps its software-written value. If the line changes in the same cycle as a write to word 4 or word 5, the line's new value wins.
- R10: Reads of words 3, 5 and 11 and of unmapped words return zero. Writes to words 0, 1, 8 and 9 and to unmapped words change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC (32) | Level-sensitive interrupt source lines |
| bus_wr_i | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the word at `bus_addr_i` (combinational) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach is the contest on raw bit 0. A change on source line 0 must land in exactly the same clock cycle as a software clear. Separately, a software write must be shown to survive while the line holds steady, and a later line change must be shown to override that write. The bench drives the line change and the write strobe on the same falling edge, so both are sampled at one rising edge. It then reads word 4 to observe which of the two won. It also walks the raw bit through the sequence soft set, rising edge, falling edge and soft set with the line steady, reading word 4 after each step.

// File: rtl/lvlint_pkg.sv
package lvlint_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] waddr_t;

    // word map: the decoder in every submodule depends on these values
    localparam waddr_t ADR_IRQ_STAT   = 4'd0;
    localparam waddr_t ADR_RAW        = 4'd1;
    localparam waddr_t ADR_IRQ_EN_SET = 4'd2;
    localparam waddr_t ADR_IRQ_EN_CLR = 4'd3;
    localparam waddr_t ADR_SOFT_SET   = 4'd4;
    localparam waddr_t ADR_SOFT_CLR   = 4'd5;
    localparam waddr_t ADR_FIQ_STAT   = 4'd8;
    localparam waddr_t ADR_FIQ_RAW    = 4'd9;
    localparam waddr_t ADR_FIQ_EN_SET = 4'd10;
    localparam waddr_t ADR_FIQ_EN_CLR = 4'd11;
endpackage

// File: rtl/lvlint_raw.sv
module lvlint_raw
    import lvlint_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic             wr_i,
    input  waddr_t           addr_i,
    input  logic             wd0_i,
    output logic [N_SRC-1:0] raw_o
);
    typedef struct packed {
        logic [N_SRC-1:0] raw;
        logic             prev0;
    } raw_st_t;

    raw_st_t s_d, s_q;
    logic    soft_set, soft_clr, edge0;

    always_comb begin
        soft_set = wr_i && (addr_i == ADR_SOFT_SET) && wd0_i;
        soft_clr = wr_i && (addr_i == ADR_SOFT_CLR) && wd0_i;
        edge0    = (src_i[0] != s_q.prev0);
        s_d       = s_q;
        s_d.prev0 = src_i[0];
        s_d.raw   = src_i;
        if (!edge0) begin
            if (soft_set)      s_d.raw[0] = 1'b1;
            else if (soft_clr) s_d.raw[0] = 1'b0;
            else               s_d.raw[0] = s_q.raw[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign raw_o = s_q.raw;

    generate
        if (N_SRC > 1) begin : g_upper_chk
            p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> raw_o[N_SRC-1:1] == $past(src_i[N_SRC-1:1]));
        end
    endgenerate

    p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i[0] != s_q.prev0) |=> raw_o[0] == $past(src_i[0]));

    p_steady_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge0 && !soft_set && !soft_clr) |=> $stable(raw_o[0]));

    p_soft_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_set && !edge0) |=> raw_o[0]);

    p_soft_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_clr && !edge0) |=> !raw_o[0]);
endmodule

// File: rtl/lvlint_mask.sv
module lvlint_mask
    import lvlint_pkg::*;
#(
    parameter int     N_SRC = 32,
    parameter waddr_t SET_A = ADR_IRQ_EN_SET,
    parameter waddr_t CLR_A = ADR_IRQ_EN_CLR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  waddr_t           addr_i,
    input  logic [N_SRC-1:0] wdata_i,
    output logic [N_SRC-1:0] mask_o
);
    typedef struct packed {
        logic [N_SRC-1:0] mask;
    } mask_st_t;

    mask_st_t s_d, s_q;
    logic     hit_set, hit_clr;

    always_comb begin
        hit_set = wr_i && (addr_i == SET_A);
        hit_clr = wr_i && (addr_i == CLR_A);
        s_d = s_q;
        if (hit_set)      s_d.mask = s_q.mask | wdata_i;
        else if (hit_clr) s_d.mask = s_q.mask & ~wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mask_o = s_q.mask;

    // R3 for the normal mask, R5 for the fast mask
    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_set |=> ((mask_o & $past(wdata_i)) == $past(wdata_i))
                 && ((mask_o & ~$past(wdata_i)) == ($past(mask_o) & ~$past(wdata_i))));

    p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_clr |=> ((mask_o & $past(wdata_i)) == '0)
                 && ((mask_o & ~$past(wdata_i)) == ($past(mask_o) & ~$past(wdata_i))));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_set || hit_clr) |=> $stable(mask_o));
endmodule

// File: rtl/lvlint_rdmux.sv
module lvlint_rdmux
    import lvlint_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  waddr_t           addr_i,
    input  logic [N_SRC-1:0] raw_i,
    input  logic [N_SRC-1:0] irq_en_i,
    input  logic [N_SRC-1:0] fiq_en_i,
    output word_t            rdata_o
);
    always_comb begin
        unique case (addr_i)
            ADR_IRQ_STAT:   rdata_o = word_t'(raw_i & irq_en_i);
            ADR_RAW:        rdata_o = word_t'(raw_i);
            ADR_IRQ_EN_SET: rdata_o = word_t'(irq_en_i);
            ADR_SOFT_SET:   rdata_o = word_t'(raw_i[0]);
            ADR_FIQ_STAT:   rdata_o = word_t'(raw_i & fiq_en_i);
            ADR_FIQ_RAW:    rdata_o = word_t'(raw_i);
            ADR_FIQ_EN_SET: rdata_o = word_t'(fiq_en_i);
            default:        rdata_o = '0;
        endcase
    end

    always_comb begin
        if (addr_i == ADR_IRQ_EN_CLR || addr_i == ADR_SOFT_CLR || addr_i == ADR_FIQ_EN_CLR)
            p_clr_rd_zero_r10: assert (rdata_o == '0);
    end
endmodule

// File: rtl/lvlint_ctrl.sv
module lvlint_ctrl
    import lvlint_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic             bus_wr_i,
    input  logic [3:0]       bus_addr_i,
    input  logic [31:0]      bus_wdata_i,
    output logic [31:0]      bus_rdata_o,
    output logic             irq_o,
    output logic             fiq_o
);
    logic [N_SRC-1:0] raw, irq_en, fiq_en;

    lvlint_raw #(.N_SRC(N_SRC)) u_raw (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_i(bus_wr_i),
        .addr_i(bus_addr_i), .wd0_i(bus_wdata_i[0]), .raw_o(raw)
    );

    lvlint_mask #(.N_SRC(N_SRC), .SET_A(ADR_IRQ_EN_SET), .CLR_A(ADR_IRQ_EN_CLR)) u_irq_mask (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
        .wdata_i(bus_wdata_i[N_SRC-1:0]), .mask_o(irq_en)
    );

    lvlint_mask #(.N_SRC(N_SRC), .SET_A(ADR_FIQ_EN_SET), .CLR_A(ADR_FIQ_EN_CLR)) u_fiq_mask (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
        .wdata_i(bus_wdata_i[N_SRC-1:0]), .mask_o(fiq_en)
    );

    lvlint_rdmux #(.N_SRC(N_SRC)) u_rdmux (
        .addr_i(bus_addr_i), .raw_i(raw), .irq_en_i(irq_en),
        .fiq_en_i(fiq_en), .rdata_o(bus_rdata_o)
    );

    assign irq_o = |(raw & irq_en);
    assign fiq_o = |(raw & fiq_en);

    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (raw == '0) |-> (!irq_o && !fiq_o));

    p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq_o);

    p_fiq_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_en == '0) |-> !fiq_o);
endmodule

// File: tb/lvlint_ctrl_tb.sv
`timescale 1ns/1ps
module lvlint_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    typedef struct {
        bit          is_out;
        logic [3:0]  a;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    always #4 clk = ~clk;

    lvlint_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
    );

    task automatic exp_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        addr = a;
        sbq.push_back('{1'b0, a, e, tag});
    endtask

    task automatic exp_out(input logic fq, input logic iq, input string tag);
        @(negedge clk);
        sbq.push_back('{1'b1, 4'd0, {30'd0, fq, iq}, tag});
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        src = v;
        @(negedge clk);
    endtask

    task automatic src_and_wr(input logic [31:0] v, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        src = v; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    // monitor: compares one queued item per cycle, shortly after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sbq.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it = sbq.pop_front();
                got = it.is_out ? {30'd0, fiq, irq} : rdata;
                n_chk++;
                if (got !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s word=%0d out=%0b actual=%h expected=%h",
                             it.tag, it.a, it.is_out, got, it.exp);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        exp_rd(4'd0, 32'h0, "R1 irq status");
        exp_rd(4'd1, 32'h0, "R1 raw");
        exp_rd(4'd2, 32'h0, "R1 irq mask");
        exp_rd(4'd4, 32'h0, "R1 soft");
        exp_rd(4'd8, 32'h0, "R1 fiq status");
        exp_rd(4'd10, 32'h0, "R1 fiq mask");
        exp_out(1'b0, 1'b0, "R1 outputs");
        // R2 raw follows inputs
        set_src(32'hA5A5_0F00);
        exp_rd(4'd1, 32'hA5A5_0F00, "R2 raw word1");
        exp_rd(4'd9, 32'hA5A5_0F00, "R2 raw word9");
        set_src(32'h5A5A_F0F0);
        exp_rd(4'd1, 32'h5A5A_F0F0, "R2 raw pattern2");
        set_src(32'hA5A5_0F00);
        exp_rd(4'd1, 32'hA5A5_0F00, "R2 raw pattern3");
        // R3 set mask, OR behaviour
        do_wr(4'd2, 32'h0000_0F0F);
        exp_rd(4'd2, 32'h0000_0F0F, "R3 set mask");
        do_wr(4'd2, 32'h0100_0000);
        exp_rd(4'd2, 32'h0100_0F0F, "R3 OR into mask");
        exp_rd(4'd0, 32'h0100_0F00, "R6 irq status");
        exp_out(1'b0, 1'b1, "R7 irq high");
        // R4 clear mask bits
        do_wr(4'd3, 32'h0000_0F00);
        exp_rd(4'd2, 32'h0100_000F, "R4 partial clear");
        exp_rd(4'd0, 32'h0100_0000, "R6 status after clear");
        do_wr(4'd3, 32'h0100_0000);
        exp_rd(4'd2, 32'h0000_000F, "R4 clear last");
        exp_out(1'b0, 1'b0, "R7 irq low");
        // R5 fast mask
        do_wr(4'd10, 32'h8000_0000);
        exp_rd(4'd10, 32'h8000_0000, "R5 fiq mask set");
        exp_rd(4'd8, 32'h8000_0000, "R6 fiq status");
        exp_out(1'b1, 1'b0, "R7 fiq high");
        do_wr(4'd11, 32'h8000_0000);
        exp_rd(4'd10, 32'h0, "R5 fiq mask clear");
        exp_out(1'b0, 1'b0, "R7 fiq low");
        // R10 ignored writes and zero reads
        do_wr(4'd0, 32'hFFFF_FFFF);
        do_wr(4'd1, 32'hFFFF_FFFF);
        do_wr(4'd8, 32'hFFFF_FFFF);
        do_wr(4'd9, 32'hFFFF_FFFF);
        do_wr(4'd6, 32'hFFFF_FFFF);
        exp_rd(4'd2, 32'h0000_000F, "R10 irq mask untouched");
        exp_rd(4'd10, 32'h0, "R10 fiq mask untouched");
        exp_rd(4'd1, 32'hA5A5_0F00, "R10 raw untouched");
        exp_rd(4'd3, 32'h0, "R10 read word3");
        exp_rd(4'd5, 32'h0, "R10 read word5");
        exp_rd(4'd11, 32'h0, "R10 read word11");
        exp_rd(4'd7, 32'h0, "R10 read unmapped");
        // R8 software trigger on bit 0
        do_wr(4'd4, 32'h1);
        exp_rd(4'd4, 32'h1, "R8 soft set");
        exp_rd(4'd1, 32'hA5A5_0F01, "R8 raw bit0");
        exp_out(1'b0, 1'b1, "R8 irq from soft");
        do_wr(4'd5, 32'h1);
        exp_rd(4'd4, 32'h0, "R8 soft clear");
        exp_out(1'b0, 1'b0, "R8 irq off");
        do_wr(4'd4, 32'h2);
        exp_rd(4'd4, 32'h0, "R8 bit0 clear no effect");
        // R9 shared bit 0 ordering
        do_wr(4'd4, 32'h1);
        set_src(32'hA5A5_0F01);
        exp_rd(4'd4, 32'h1, "R9 rise keeps 1");
        set_src(32'hA5A5_0F00);
        exp_rd(4'd4, 32'h0, "R9 fall overrides soft");
        do_wr(4'd4, 32'h1);
        exp_rd(4'd4, 32'h1, "R9 steady low keeps soft");
        src_and_wr(32'hA5A5_0F01, 4'd5, 32'h1);
        exp_rd(4'd4, 32'h1, "R9 edge beats clear");
        do_wr(4'd5, 32'h1);
        exp_rd(4'd4, 32'h0, "R9 clear with line high");
        exp_rd(4'd1, 32'hA5A5_0F00, "R9 raw bit0 low");
        exp_out(1'b0, 1'b0, "R9 outputs");
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule